// File: doc/BRIEF.md
# Pipeline Control Word Carrier

This block decodes each instruction's control word once, while the instruction sits in the decode stage, and then carries that word down an in-order pipeline beside the instruction. The word has three groups: the execute group, the memory group and the writeback group. Each group is registered forward until its stage uses it. Each pipeline register drops the groups that its earlier stages have already used. The execute group therefore appears one cycle after decode, the memory group two cycles after decode and the writeback group three cycles after decode.

An outside hazard or exception unit steers the chain. It does so through per-stage freeze and bubble commands and a single flush line. A freeze at a stage holds every pipeline register above that stage and drains a bubble into the register below it. A bubble is the all-zero control word, in which every state-changing enable is cleared. A branch does not squash anything, so the instruction behind it in the delay slot always runs to completion.

Top module: `pipe_ctrl_chain`

## Requirements
- R1: Decoding uses a 4-bit opcode and a 2-bit function field. The ALU operation code is 00 add, 01 sub, 10 and, 11 or. Opcode 0 (register ALU) gives alu_op equal to the function field, rd_sel 1 and reg_wr 1. Opcode 1 (add immediate) gives ext_sign 1, alu_src 1, add and reg_wr 1. Opcode 2 (or immediate) gives ext_sign 0, alu_src 1, or and reg_wr 1. Opcode 3 (load) gives ext_sign 1, alu_src 1, add, load_sel 1 and reg_wr 1. Opcode 4 (store) gives ext_sign 1, alu_src 1, add and mem_wr 1. Opcode 5 (branch on equal) gives alu_src 0, sub and branch 1. Every field not listed is 0.
- R2: With no freeze, bubble or flush, the execute-group outputs equal the decoded word of the instruction that was in decode one clock earlier.
- R3: With no freeze, bubble or flush, the memory-group outputs carry the decoded word from two clocks earlier and the writeback-group outputs carry it from three clocks earlier.
- R4: While reset is asserted (active-low, asynchronous), every stage holds a bubble, so all outputs are 0.
- R5: freeze bit k (0 = decode, 1 = execute, 2 = memory) holds every pipeline register that feeds a stage above k. It loads a bubble into the register that feeds stage k+1.
- R6: bubble bit k loads a bubble into the register that feeds stage k+1. If that register is also being held by a freeze further down, the hold wins and the register keeps its contents.
- R7: flush clears the execute, memory and writeback output registers on the next clock. It overrides any freeze or bubble.
- R8: A branch in flight squashes nothing. The instruction that follows it in decode reaches execute, memory and writeback unchanged.
- R9: Opcodes 6 to 15 decode to a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op | input | 4 | Opcode of the instruction in decode |
| dec_fn | input | 2 | Function field of the instruction in decode |
| frz | input | 3 | Per-stage freeze: bit 0 decode, bit 1 execute, bit 2 memory |
| bub | input | 3 | Per-stage bubble into the register after decode, execute, memory |
| flush | input | 1 | Clear all in-flight control words |
| ex_ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| ex_alu_src | output | 1 | ALU second operand: 1 immediate, 0 register |
| ex_alu_op | output | 2 | ALU operation |
| ex_rd_sel | output | 1 | Destination register: 1 rd field, 0 rt field |
| mem_wr | output | 1 | Data memory write enable |
| mem_branch | output | 1 | Branch instruction in memory stage |
| wb_load_sel | output | 1 | Writeback source: 1 memory data, 0 ALU result |
| wb_reg_wr | output | 1 | Register file write enable |

## Verification
The hardest situations to reach are the overlaps. These include a freeze further down the pipe that must beat a bubble request higher up, and a flush that arrives while stages are frozen, so that a held word must still be cleared. Such overlaps seldom occur when every input is drawn uniformly. The random phase therefore raises the rate of freeze, bubble and flush requests, and directed cycles apply a memory freeze together with an execute bubble, and a flush together with a full freeze. A short directed sequence puts a branch immediately ahead of an add immediate and follows the delay-slot word through all three stages.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OP_W  = 4;
  localparam int FN_W  = 2;
  localparam int ALU_W = FN_W;

  localparam logic [OP_W-1:0] OPC_RALU  = 4'd0;
  localparam logic [OP_W-1:0] OPC_ADDI  = 4'd1;
  localparam logic [OP_W-1:0] OPC_ORI   = 4'd2;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd3;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd4;
  localparam logic [OP_W-1:0] OPC_BEQ   = 4'd5;

  localparam logic [ALU_W-1:0] ALU_ADD = 2'd0;
  localparam logic [ALU_W-1:0] ALU_SUB = 2'd1;
  localparam logic [ALU_W-1:0] ALU_AND = 2'd2;
  localparam logic [ALU_W-1:0] ALU_OR  = 2'd3;

  typedef struct packed {
    logic             ext_sign;
    logic             alu_src;
    logic [ALU_W-1:0] alu_op;
    logic             rd_sel;
  } ex_ctrl_t;

  typedef struct packed {
    logic wr;
    logic branch;
  } mem_ctrl_t;

  typedef struct packed {
    logic load_sel;
    logic reg_wr;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } ctrl_word_t;

  localparam int EX_W  = $bits(ex_ctrl_t);
  localparam int MEM_W = $bits(mem_ctrl_t);
  localparam int WB_W  = $bits(wb_ctrl_t);
  localparam int CW_W  = $bits(ctrl_word_t);
  localparam int NSTG  = 3;
endpackage

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output ctrl_word_t      cw
);
  always_comb begin
    cw = '0;
    unique case (op)
      OPC_RALU: begin
        cw.ex.alu_op = fn;
        cw.ex.rd_sel = 1'b1;
        cw.wb.reg_wr = 1'b1;
      end
      OPC_ADDI: begin
        cw.ex.ext_sign = 1'b1;
        cw.ex.alu_src  = 1'b1;
        cw.ex.alu_op   = ALU_ADD;
        cw.wb.reg_wr   = 1'b1;
      end
      OPC_ORI: begin
        cw.ex.alu_src = 1'b1;
        cw.ex.alu_op  = ALU_OR;
        cw.wb.reg_wr  = 1'b1;
      end
      OPC_LOAD: begin
        cw.ex.ext_sign = 1'b1;
        cw.ex.alu_src  = 1'b1;
        cw.ex.alu_op   = ALU_ADD;
        cw.wb.load_sel = 1'b1;
        cw.wb.reg_wr   = 1'b1;
      end
      OPC_STORE: begin
        cw.ex.ext_sign = 1'b1;
        cw.ex.alu_src  = 1'b1;
        cw.ex.alu_op   = ALU_ADD;
        cw.mem.wr      = 1'b1;
      end
      OPC_BEQ: begin
        cw.ex.alu_op  = ALU_SUB;
        cw.mem.branch = 1'b1;
      end
      default: cw = '0;
    endcase
  end
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         kill,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    if (kill)      q_nxt = '0;
    else if (hold) q_nxt = q;
    else           q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pipe_ctrl_chain.sv
module pipe_ctrl_chain
  import ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  dec_op,
  input  logic [FN_W-1:0]  dec_fn,
  input  logic [NSTG-1:0]  frz,
  input  logic [NSTG-1:0]  bub,
  input  logic             flush,
  output logic             ex_ext_sign,
  output logic             ex_alu_src,
  output logic [ALU_W-1:0] ex_alu_op,
  output logic             ex_rd_sel,
  output logic             mem_wr,
  output logic             mem_branch,
  output logic             wb_load_sel,
  output logic             wb_reg_wr
);
  localparam int EXM_W = MEM_W + WB_W;

  ctrl_word_t        dec_cw;
  logic [NSTG-1:0]   stg_hold;
  logic [NSTG-1:0]   stg_kill;
  logic [CW_W-1:0]   idex_q;
  logic [EXM_W-1:0]  exmem_q;
  logic [WB_W-1:0]   memwb_q;
  ctrl_word_t        idex_cw;

  ctrl_decoder u_dec (
    .op (dec_op),
    .fn (dec_fn),
    .cw (dec_cw)
  );

  // A freeze at stage k holds every register feeding a stage above k;
  // the register right after stage k takes a bubble unless it is held.
  for (genvar i = 0; i < NSTG; i++) begin : g_ctl
    assign stg_hold[i] = ((frz >> (i + 1)) != '0);
    assign stg_kill[i] = flush | ((frz[i] | bub[i]) & ~stg_hold[i]);
  end

  pipe_stage_reg #(.W(CW_W)) u_idex (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (stg_hold[0]),
    .kill (stg_kill[0]),
    .d    (dec_cw),
    .q    (idex_q)
  );

  assign idex_cw = ctrl_word_t'(idex_q);

  pipe_stage_reg #(.W(EXM_W)) u_exmem (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (stg_hold[1]),
    .kill (stg_kill[1]),
    .d    ({idex_cw.mem, idex_cw.wb}),
    .q    (exmem_q)
  );

  pipe_stage_reg #(.W(WB_W)) u_memwb (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (stg_hold[2]),
    .kill (stg_kill[2]),
    .d    (exmem_q[WB_W-1:0]),
    .q    (memwb_q)
  );

  assign ex_ext_sign = idex_cw.ex.ext_sign;
  assign ex_alu_src  = idex_cw.ex.alu_src;
  assign ex_alu_op   = idex_cw.ex.alu_op;
  assign ex_rd_sel   = idex_cw.ex.rd_sel;
  assign mem_wr      = exmem_q[EXM_W-1];
  assign mem_branch  = exmem_q[EXM_W-2];
  assign wb_load_sel = memwb_q[1];
  assign wb_reg_wr   = memwb_q[0];
endmodule

// File: rtl/pipe_ctrl_chain_chk.sv
module pipe_ctrl_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] dec_op,
  input logic [2:0] frz,
  input logic [2:0] bub,
  input logic       flush,
  input logic [4:0] ex_bus,
  input logic [1:0] mem_bus,
  input logic [1:0] wb_bus,
  input logic [1:0] exmem_wb
);
  logic clean;
  assign clean = (frz == 3'b000) && (bub == 3'b000) && !flush;

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ex_bus == 5'd0) && (mem_bus == 2'd0) && (wb_bus == 2'd0));

  assert_mem_freeze_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz[2] && !flush) |=> $stable(ex_bus) && $stable(mem_bus) && (wb_bus == 2'd0));

  assert_ex_freeze_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz[1] && !frz[2] && !flush) |=> $stable(ex_bus) && (mem_bus == 2'd0));

  assert_dec_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((frz[0] || bub[0]) && !frz[1] && !frz[2] && !flush) |=> (ex_bus == 5'd0));

  assert_store_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_op == 4'd4) && clean) |=> (ex_bus == 5'b11000));

  assert_undef_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_op > 4'd5) && !frz[1] && !frz[2] && !flush) |=> (ex_bus == 5'd0));

  assert_wb_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clean |=> (wb_bus == $past(exmem_wb)));
endmodule

bind pipe_ctrl_chain pipe_ctrl_chain_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dec_op  (dec_op),
  .frz     (frz),
  .bub     (bub),
  .flush   (flush),
  .ex_bus  ({ex_ext_sign, ex_alu_src, ex_alu_op, ex_rd_sel}),
  .mem_bus ({mem_wr, mem_branch}),
  .wb_bus  ({wb_load_sel, wb_reg_wr}),
  .exmem_wb(exmem_q[1:0])
);

// File: tb/tb_pipe_ctrl_chain.sv
module tb_pipe_ctrl_chain;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dec_op;
  logic [1:0] dec_fn;
  logic [2:0] frz;
  logic [2:0] bub;
  logic       flush;
  logic       ex_ext_sign, ex_alu_src, ex_rd_sel;
  logic [1:0] ex_alu_op;
  logic       mem_wr, mem_branch, wb_load_sel, wb_reg_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference stage contents: [8]sign [7]src [6:5]aluop [4]rd [3]mw [2]br [1]ld [0]rw
  logic [8:0] m0;
  logic [3:0] m1;
  logic [1:0] m2;

  always #5 clk = ~clk;

  pipe_ctrl_chain dut (
    .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .dec_fn(dec_fn),
    .frz(frz), .bub(bub), .flush(flush),
    .ex_ext_sign(ex_ext_sign), .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op),
    .ex_rd_sel(ex_rd_sel), .mem_wr(mem_wr), .mem_branch(mem_branch),
    .wb_load_sel(wb_load_sel), .wb_reg_wr(wb_reg_wr)
  );

  function automatic logic [8:0] ref_decode(input logic [3:0] op, input logic [1:0] fn);
    case (op)
      4'd0: return {2'b00, fn, 1'b1, 2'b00, 2'b01};
      4'd1: return {2'b11, 2'b00, 1'b0, 2'b00, 2'b01};
      4'd2: return {2'b01, 2'b11, 1'b0, 2'b00, 2'b01};
      4'd3: return {2'b11, 2'b00, 1'b0, 2'b00, 2'b11};
      4'd4: return {2'b11, 2'b00, 1'b0, 2'b10, 2'b00};
      4'd5: return {2'b00, 2'b01, 1'b0, 2'b01, 2'b00};
      default: return 9'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string t_ex, input string t_mem, input string t_wb);
    check(t_ex,  "ex group",  int'({ex_ext_sign, ex_alu_src, ex_alu_op, ex_rd_sel}), int'(m0[8:4]));
    check(t_mem, "mem group", int'({mem_wr, mem_branch}), int'(m1[3:2]));
    check(t_wb,  "wb group",  int'({wb_load_sel, wb_reg_wr}), int'(m2));
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic [3:0] op, input logic [1:0] fn, input logic [2:0] f,
                     input logic [2:0] b, input logic fl, input string tag);
    logic [8:0] n0;
    logic [3:0] n1;
    logic [1:0] n2;
    string te, tm, tw;
    dec_op = op; dec_fn = fn; frz = f; bub = b; flush = fl;
    @(posedge clk);
    n0 = fl ? 9'd0 : (f[1] | f[2]) ? m0 : (f[0] | b[0]) ? 9'd0 : ref_decode(op, fn);
    n1 = fl ? 4'd0 : f[2] ? m1 : (f[1] | b[1]) ? 4'd0 : m0[3:0];
    n2 = fl ? 2'd0 : (f[2] | b[2]) ? 2'd0 : m1[1:0];
    m0 = n0; m1 = n1; m2 = n2;
    @(negedge clk);
    if (tag != "")    begin te = tag;  tm = tag;  tw = tag;  end
    else if (fl)      begin te = "R7"; tm = "R7"; tw = "R7"; end
    else if (f != 0)  begin te = "R5"; tm = "R5"; tw = "R5"; end
    else if (b != 0)  begin te = "R6"; tm = "R6"; tw = "R6"; end
    else              begin te = "R2"; tm = "R3"; tw = "R3"; end
    compare(te, tm, tw);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m0 = '0; m1 = '0; m2 = '0;
    #3;
    compare("R4", "R4", "R4");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    dec_op = '0; dec_fn = '0; frz = '0; bub = '0; flush = 1'b0;
    rst_n = 1'b0;
    m0 = '0; m1 = '0; m2 = '0;
    @(negedge clk);
    @(negedge clk);
    compare("R4", "R4", "R4");
    rst_n = 1'b1;

    // R1: decode table, each word followed through its stages
    for (int op = 0; op < 6; op++) begin
      for (int fn = 0; fn < 4; fn++) cyc(4'(op), 2'(fn), 3'b000, 3'b000, 1'b0, "R1");
    end
    // R9: undefined opcodes decode to bubble
    for (int op = 6; op < 16; op++) cyc(4'(op), 2'd3, 3'b000, 3'b000, 1'b0, "R9");
    // R8: branch followed by delay-slot instruction, nothing squashed
    cyc(4'd5, 2'd0, 3'b000, 3'b000, 1'b0, "R8");
    cyc(4'd1, 2'd0, 3'b000, 3'b000, 1'b0, "R8");
    cyc(4'd3, 2'd0, 3'b000, 3'b000, 1'b0, "R8");
    cyc(4'd0, 2'd2, 3'b000, 3'b000, 1'b0, "R8");
    cyc(4'd0, 2'd2, 3'b000, 3'b000, 1'b0, "R8");
    // fill, then R5: memory freeze beats an execute bubble (R6 priority)
    cyc(4'd4, 2'd0, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd3, 2'd0, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd0, 2'd1, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd2, 2'd0, 3'b100, 3'b011, 1'b0, "R6");
    cyc(4'd2, 2'd0, 3'b010, 3'b000, 1'b0, "R5");
    cyc(4'd2, 2'd0, 3'b001, 3'b000, 1'b0, "R5");
    // R7: flush during full freeze
    cyc(4'd3, 2'd0, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd4, 2'd0, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd1, 2'd0, 3'b111, 3'b111, 1'b1, "R7");
    // R4: reset in the middle of traffic
    cyc(4'd3, 2'd0, 3'b000, 3'b000, 1'b0, "");
    cyc(4'd4, 2'd0, 3'b000, 3'b000, 1'b0, "");
    do_reset();

    // random traffic with frequent control requests
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] f, b;
      logic fl;
      f  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      b  = ($urandom % 5 == 0) ? 3'($urandom) : 3'b000;
      fl = ($urandom % 16 == 0);
      cyc(4'($urandom % 8), 2'($urandom), f, b, fl, "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule